// File: doc/BRIEF.md
# Dual-Edge Delay Gate Sequencer

This block turns a single PWM command into four gate-drive enables for a converter with two complementary primary switches and two synchronous rectifiers. Every output is held in a set/clear latch, and each latch is driven by its own pair of programmable delay counters. One counter of the pair is started by the edge that should switch the output on. The other is started by the edge that should switch it off. When a counter expires it issues a one-cycle request to its latch. Because every output edge has its own counter, the width, the position and the dead time of each enable are set independently by register inputs, in system clock cycles.

The primary pair is timed from the PWM input. Output A follows the high phase and output B follows the low phase. Dead time comes from programming the turn-on delays longer than the turn-off delays. A hard interlock keeps A and B from ever being on together, even when the delays are programmed badly. Each rectifier is timed from one primary output. Rectifier A is the delayed inverse of primary B, and rectifier B is the delayed inverse of primary A. Both rectifiers are therefore on together while the primaries swap, and a rectifier releases only after a programmed delay once its primary has turned on.

All pins are plain control pins: the block has no data stream, so it has no valid/ready handshake and no back-pressure. The delay inputs must be held steady while an edge is being timed.

Top module: `gate_seq_top`

## Requirements
- R1: During the synchronous reset, and afterwards until the PWM input has shown a falling edge followed by a rising edge, all four outputs stay low and no PWM edge starts any timing. That rising edge is the first one to take effect.
- R2: Let k be the clock edge that first samples a new PWM level. A rising PWM edge sets primary A on clock edge k+1+d, where d is dly_pa_on. A falling PWM edge clears primary A on edge k+1+d, where d is dly_pa_off.
- R3: A falling PWM edge sets primary B on edge k+1+dly_pb_on. A rising PWM edge clears primary B on edge k+1+dly_pb_off.
- R4: If primary B changes on clock edge P, rectifier A changes on edge P+1+d. It sets after B falls, with d = dly_ra_on, and clears after B rises, with d = dly_ra_off. Rectifier B does the same from primary A, using dly_rb_on and dly_rb_off.
- R5: A delay of zero changes the output on the clock edge right after the detecting edge: edge k+1 for a primary, and edge P+1 for a rectifier.
- R6: An edge of the same kind that arrives while that edge's counter is still running restarts the counter from the new edge. The earlier pending change is discarded.
- R7: If an output's set request and clear request fall on the same clock edge, the clear wins and the output ends that edge low.
- R8: Primary A and primary B are never high together. A set request for A is discarded while B is high. A set request for B is discarded while A is high, or when A's set request falls on the same edge.
- R9: When a primary output's two delays are equal, its high time equals the PWM high time (or low time, for B) in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM command |
| dly_pa_on | input | DLY_W | Primary A turn-on delay after a PWM rise |
| dly_pa_off | input | DLY_W | Primary A turn-off delay after a PWM fall |
| dly_pb_on | input | DLY_W | Primary B turn-on delay after a PWM fall |
| dly_pb_off | input | DLY_W | Primary B turn-off delay after a PWM rise |
| dly_ra_on | input | DLY_W | Rectifier A turn-on delay after primary B falls |
| dly_ra_off | input | DLY_W | Rectifier A turn-off delay after primary B rises |
| dly_rb_on | input | DLY_W | Rectifier B turn-on delay after primary A falls |
| dly_rb_off | input | DLY_W | Rectifier B turn-off delay after primary A rises |
| gate_pa | output | 1 | Primary A enable |
| gate_pb | output | 1 | Primary B enable |
| gate_ra | output | 1 | Rectifier A enable |
| gate_rb | output | 1 | Rectifier B enable |

## Verification
The hardest conditions to reach from the ports are collisions in time. These are a counter restarted while it is still running, and a set request landing on the same edge as a clear request. The stimulus creates them on purpose. It uses a PWM pulse shorter than the programmed turn-on delay, and it picks a pulse width so that the turn-on and turn-off expirations of one output coincide exactly. The interlock is exercised by programming overlapping delays on purpose, first on the rising PWM edge and then on the falling one. The bench then confirms that the blocked output never rises during that period.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  localparam int GS_NCH = 4;
  localparam int CH_PA  = 0;
  localparam int CH_PB  = 1;
  localparam int CH_RA  = 2;
  localparam int CH_RB  = 3;
endpackage

// File: rtl/gs_edge_det.sv
module gs_edge_det #(
  parameter bit SAMPLE_IN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic cur;
  logic prev;

  if (SAMPLE_IN) begin : g_smp
    always_ff @(posedge clk) begin
      if (rst) cur <= 1'b0;
      else     cur <= din;
    end
  end else begin : g_direct
    assign cur = din;
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
endmodule

// File: rtl/gs_delay_chain.sv
module gs_delay_chain #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt;
  logic             busy;

  // a fresh start overrides any expiry of the previous run
  assign fire = start ? (dly == '0) : (busy && cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= (dly != '0);
      cnt  <= dly - ONE;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - ONE;
    end
  end
endmodule

// File: rtl/gs_channel.sv
module gs_channel #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_on,
  input  logic             start_off,
  input  logic [DLY_W-1:0] dly_on,
  input  logic [DLY_W-1:0] dly_off,
  input  logic             inhibit_on,
  output logic             on_fire,
  output logic             off_fire,
  output logic             q
);
  gs_delay_chain #(.DLY_W(DLY_W)) u_on (
    .clk(clk), .rst(rst), .start(start_on), .dly(dly_on), .fire(on_fire)
  );

  gs_delay_chain #(.DLY_W(DLY_W)) u_off (
    .clk(clk), .rst(rst), .start(start_off), .dly(dly_off), .fire(off_fire)
  );

  always_ff @(posedge clk) begin
    if (rst)                          q <= 1'b0;
    else if (off_fire)                q <= 1'b0;
    else if (on_fire && !inhibit_on)  q <= 1'b1;
  end
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gate_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_in,
  input  logic [DLY_W-1:0] dly_pa_on,
  input  logic [DLY_W-1:0] dly_pa_off,
  input  logic [DLY_W-1:0] dly_pb_on,
  input  logic [DLY_W-1:0] dly_pb_off,
  input  logic [DLY_W-1:0] dly_ra_on,
  input  logic [DLY_W-1:0] dly_ra_off,
  input  logic [DLY_W-1:0] dly_rb_on,
  input  logic [DLY_W-1:0] dly_rb_off,
  output logic             gate_pa,
  output logic             gate_pb,
  output logic             gate_ra,
  output logic             gate_rb
);
  logic [GS_NCH-1:0] st_on;
  logic [GS_NCH-1:0] st_off;
  logic [GS_NCH-1:0] inh;
  logic [GS_NCH-1:0] on_fire;
  logic [GS_NCH-1:0] off_fire;
  logic [GS_NCH-1:0] gq;
  logic [DLY_W-1:0]  d_on  [GS_NCH];
  logic [DLY_W-1:0]  d_off [GS_NCH];

  logic pwm_rise, pwm_fall;
  logic pa_rise, pa_fall, pb_rise, pb_fall;
  logic seen_fall, armed, arm_ok;

  assign d_on[CH_PA]  = dly_pa_on;
  assign d_off[CH_PA] = dly_pa_off;
  assign d_on[CH_PB]  = dly_pb_on;
  assign d_off[CH_PB] = dly_pb_off;
  assign d_on[CH_RA]  = dly_ra_on;
  assign d_off[CH_RA] = dly_ra_off;
  assign d_on[CH_RB]  = dly_rb_on;
  assign d_off[CH_RB] = dly_rb_off;

  gs_edge_det #(.SAMPLE_IN(1'b1)) u_pwm_edge (
    .clk(clk), .rst(rst), .din(pwm_in), .rise(pwm_rise), .fall(pwm_fall)
  );
  gs_edge_det #(.SAMPLE_IN(1'b0)) u_pa_edge (
    .clk(clk), .rst(rst), .din(gq[CH_PA]), .rise(pa_rise), .fall(pa_fall)
  );
  gs_edge_det #(.SAMPLE_IN(1'b0)) u_pb_edge (
    .clk(clk), .rst(rst), .din(gq[CH_PB]), .rise(pb_rise), .fall(pb_fall)
  );

  // timing is enabled by the first rise that follows a fall after reset
  assign arm_ok = armed | (seen_fall & pwm_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_fall <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (pwm_fall) seen_fall <= 1'b1;
      armed <= arm_ok;
    end
  end

  assign st_on[CH_PA]  = pwm_rise & arm_ok;
  assign st_off[CH_PA] = pwm_fall & armed;
  assign st_on[CH_PB]  = pwm_fall & armed;
  assign st_off[CH_PB] = pwm_rise & arm_ok;
  assign st_on[CH_RA]  = pb_fall;
  assign st_off[CH_RA] = pb_rise;
  assign st_on[CH_RB]  = pa_fall;
  assign st_off[CH_RB] = pa_rise;

  // primary interlock; B also yields to a simultaneous A request
  assign inh[CH_PA] = gq[CH_PB];
  assign inh[CH_PB] = gq[CH_PA] | on_fire[CH_PA];
  assign inh[CH_RA] = 1'b0;
  assign inh[CH_RB] = 1'b0;

  for (genvar i = 0; i < GS_NCH; i++) begin : g_ch
    gs_channel #(.DLY_W(DLY_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .start_on  (st_on[i]),
      .start_off (st_off[i]),
      .dly_on    (d_on[i]),
      .dly_off   (d_off[i]),
      .inhibit_on(inh[i]),
      .on_fire   (on_fire[i]),
      .off_fire  (off_fire[i]),
      .q         (gq[i])
    );
  end

  assign gate_pa = gq[CH_PA];
  assign gate_pb = gq[CH_PB];
  assign gate_ra = gq[CH_RA];
  assign gate_rb = gq[CH_RB];
endmodule

// File: rtl/gs_checker.sv
module gs_checker
  import gate_seq_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           armed,
  input logic [NCH-1:0] gq,
  input logic [NCH-1:0] on_fire,
  input logic [NCH-1:0] off_fire
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (gq == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (on_fire[CH_PA] && !off_fire[CH_PA] && !gq[CH_PB]) |=> gq[CH_PA]);

  p_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gq[CH_RA]) |-> $past(on_fire[CH_RA]));

  p_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(gq[CH_RB]) |-> $past(off_fire[CH_RB]));

  p_clrwin_a_r7: assert property (@(posedge clk) disable iff (rst)
    off_fire[CH_PA] |=> !gq[CH_PA]);

  p_clrwin_b_r7: assert property (@(posedge clk) disable iff (rst)
    off_fire[CH_PB] |=> !gq[CH_PB]);

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(gq[CH_PA] && gq[CH_PB]));

  p_yield_r8: assert property (@(posedge clk) disable iff (rst)
    (on_fire[CH_PA] && on_fire[CH_PB] && !gq[CH_PB]) |=> !gq[CH_PB]);
endmodule

bind gate_seq_top gs_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .armed   (armed),
  .gq      (gq),
  .on_fire (on_fire),
  .off_fire(off_fire)
);

// File: tb/gate_seq_top_tb_top.sv
module gate_seq_top_tb_top;
  localparam int DW  = 8;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic pwm = 1'b0;
  logic [DW-1:0] don  [NCH];
  logic [DW-1:0] doff [NCH];
  logic ga, gb, gra, grb;
  logic [NCH-1:0] g;
  assign g = {grb, gra, gb, ga};

  gate_seq_top #(.DLY_W(DW)) dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm),
    .dly_pa_on(don[0]), .dly_pa_off(doff[0]),
    .dly_pb_on(don[1]), .dly_pb_off(doff[1]),
    .dly_ra_on(don[2]), .dly_ra_off(doff[2]),
    .dly_rb_on(don[3]), .dly_rb_off(doff[3]),
    .gate_pa(ga), .gate_pb(gb), .gate_ra(gra), .gate_rb(grb)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // expectation model, timed in absolute cycles
  int pend_on  [NCH];
  int pend_off [NCH];
  logic [NCH-1:0] mlev, fon, foff, nl, minh, prev_g;
  bit armed_m, seen_m;
  int n;
  int qa_ch[$];
  logic qa_lv[$];
  int qa_at[$];

  int a_rise_at, a_fall_at, a_width, a_rises, b_rises, rb_rise_at, last_c;
  bit overlap_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string ch_tag(input int i);
    if (i == 0) return "R2 primary A";
    if (i == 1) return "R3 primary B";
    return "R4 rectifier";
  endfunction

  task automatic qpop();
    void'(qa_ch.pop_front());
    void'(qa_lv.pop_front());
    void'(qa_at.pop_front());
  endtask

  // monitor: advance the model, then compare observed changes
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        pend_on[i] = -1; pend_off[i] = -1;
      end
      mlev = '0; prev_g = g; armed_m = 1'b0; seen_m = 1'b0;
    end else if (!done) begin
      n = cyc;
      for (int i = 0; i < NCH; i++) begin
        fon[i]  = (pend_on[i] == n);
        foff[i] = (pend_off[i] == n);
        if (fon[i])  pend_on[i]  = -1;
        if (foff[i]) pend_off[i] = -1;
      end
      minh = '0;
      minh[0] = mlev[1];
      minh[1] = mlev[0] | fon[0];
      for (int i = 0; i < NCH; i++)
        nl[i] = foff[i] ? 1'b0 : ((fon[i] && !minh[i]) ? 1'b1 : mlev[i]);
      for (int i = 0; i < NCH; i++)
        if (nl[i] != mlev[i]) begin
          qa_ch.push_back(i); qa_lv.push_back(nl[i]); qa_at.push_back(n);
        end
      if (mlev[1] && !nl[1]) pend_on[2]  = n + 1 + int'(don[2]);
      if (!mlev[1] && nl[1]) pend_off[2] = n + 1 + int'(doff[2]);
      if (mlev[0] && !nl[0]) pend_on[3]  = n + 1 + int'(don[3]);
      if (!mlev[0] && nl[0]) pend_off[3] = n + 1 + int'(doff[3]);
      mlev = nl;

      for (int i = 0; i < NCH; i++)
        if (g[i] != prev_g[i]) begin
          if (qa_ch.size() > 0 && qa_ch[0] == i && qa_lv[0] == g[i] && qa_at[0] == n) begin
            chk(1'b1, ch_tag(i), n, n);
            qpop();
          end else begin
            chk(1'b0, ch_tag(i), n, (qa_ch.size() > 0) ? qa_at[0] : -1);
            if (qa_ch.size() > 0 && qa_at[0] <= n) qpop();
          end
        end
      while (qa_ch.size() > 0 && qa_at[0] <= n) begin
        chk(1'b0, {ch_tag(qa_ch[0]), " missed change"}, -1, qa_at[0]);
        qpop();
      end

      if (g[0] && !prev_g[0]) begin a_rise_at = n; a_rises++; end
      if (!g[0] && prev_g[0]) begin a_fall_at = n; a_width = n - a_rise_at; end
      if (g[1] && !prev_g[1]) b_rises++;
      if (g[3] && !prev_g[3]) rb_rise_at = n;
      if (g[0] && g[1]) overlap_seen = 1'b1;
      prev_g = g;
    end
  end

  // driver: changes PWM and records the expected primary timing
  task automatic edge_to(input logic lvl, input int hold_cyc);
    int c;
    @(posedge clk); #2;
    c = cyc;
    pwm = lvl;
    if (lvl) begin
      if (armed_m || seen_m) begin
        armed_m = 1'b1;
        pend_on[0]  = c + 2 + int'(don[0]);
        pend_off[1] = c + 2 + int'(doff[1]);
      end
    end else begin
      if (armed_m) begin
        pend_off[0] = c + 2 + int'(doff[0]);
        pend_on[1]  = c + 2 + int'(don[1]);
      end
      seen_m = 1'b1;
    end
    last_c = c;
    repeat (hold_cyc - 1) @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic set_pri(input int a_on, input int a_off, input int b_on, input int b_off);
    don[0] = DW'(a_on); doff[0] = DW'(a_off);
    don[1] = DW'(b_on); doff[1] = DW'(b_off);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int base, c2, fc;
    set_pri(5, 1, 5, 1);
    don[2] = 8'd1; doff[2] = 8'd3;
    don[3] = 8'd1; doff[3] = 8'd3;
    a_rises = 0; b_rises = 0; overlap_seen = 1'b0;

    // R1: reset holds everything low
    repeat (4) @(negedge clk);
    chk(g == '0, "R1 outputs in reset", int'(g), 0);
    @(posedge clk); #2; rst = 1'b0;

    // R1: rise then fall before arming leave outputs low
    edge_to(1'b1, 40); settle();
    chk(g == '0, "R1 rise before arming", int'(g), 0);
    edge_to(1'b0, 40); settle();
    chk(g == '0, "R1 fall before arming", int'(g), 0);

    // R2 R3 R4: normal periods with dead time
    for (int p = 0; p < 3; p++) begin
      edge_to(1'b1, 50);
      edge_to(1'b0, 50);
    end
    settle();
    chk(a_rises == 3, "R2 primary A pulses", a_rises, 3);

    // R9: equal delays give equal width
    set_pri(7, 7, 10, 0);
    edge_to(1'b1, 37);
    edge_to(1'b0, 50); settle();
    chk(a_width == 37, "R9 width copy", a_width, 37);

    // R5: zero delay on A turn-off and rectifier B turn-on
    set_pri(3, 0, 3, 0);
    don[3] = 8'd0;
    edge_to(1'b1, 40);
    edge_to(1'b0, 1); fc = last_c;
    repeat (40) @(posedge clk);
    settle();
    chk(a_fall_at == fc + 2, "R5 zero delay primary", a_fall_at, fc + 2);
    chk(rb_rise_at == fc + 3, "R5 zero delay rectifier", rb_rise_at, fc + 3);
    don[3] = 8'd1;

    // R6: second rise restarts a running turn-on count
    set_pri(20, 1, 5, 1);
    base = a_rises;
    edge_to(1'b1, 4);
    edge_to(1'b0, 4);
    edge_to(1'b1, 1); c2 = last_c;
    repeat (60) @(posedge clk);
    settle();
    chk(a_rises == base + 1, "R6 single restart pulse", a_rises, base + 1);
    chk(a_rise_at == c2 + 22, "R6 restart timing", a_rise_at, c2 + 22);
    edge_to(1'b0, 60);

    // R7: set and clear of A land on the same edge
    set_pri(10, 2, 4, 1);
    base = a_rises;
    edge_to(1'b1, 8);
    edge_to(1'b0, 60); settle();
    chk(a_rises == base, "R7 clear wins", a_rises, base);

    // R8: A request while B still on is discarded
    set_pri(2, 1, 3, 10);
    base = a_rises;
    edge_to(1'b1, 40); settle();
    chk(a_rises == base, "R8 A blocked by B", a_rises, base);
    edge_to(1'b0, 40);

    // R8: B request while A still on is discarded
    set_pri(3, 10, 2, 1);
    edge_to(1'b1, 40);
    base = b_rises;
    edge_to(1'b0, 40); settle();
    chk(b_rises == base, "R8 B blocked by A", b_rises, base);

    repeat (40) @(posedge clk);
    settle();
    chk(!overlap_seen, "R8 primaries never overlap", int'(overlap_seen), 0);
    chk(qa_ch.size() == 0, "R4 expected changes all seen", qa_ch.size(), 0);
    finish_run();
  end
endmodule